// File: doc/BRIEF.md
# Register Pointer With Auto-Increment

This block sits between a serial slave's byte engine and a banked register file. When the slave has matched its address for a write, the first byte that follows is taken as a command. The command's low six bits load a register pointer, and its top bit sets an auto-increment flag. Every later byte in that write goes to the pointed register, provided the register is writable. In a read the pointed register is returned byte by byte. With auto-increment set, the pointer steps after each byte, but it stays inside the five-register group (or the three control registers) that it is walking.

The map is sparse. Each five-register group starts on an eight-aligned slot: inputs from 0x00, outputs from 0x08, polarity from 0x10, configuration from 0x18 and masks from 0x20. The control registers sit at 0x28 (output structure), 0x29 (all-bank control) and 0x2A (mode). Every other address is reserved. The storage itself lives outside the block, which drives its read and write ports directly and combinationally.

Top module: `regptr_top`

## Requirements
- R1: After reset the pointer is 0x00 and auto-increment is off. No write strobe is issued and the block is idle, so incoming bytes are ignored until a select.
- R2: After a select with `rnw_i`=0, the first received byte is the command. Its bits 5:0 load the pointer and its bit 7 sets auto-increment. This byte causes no register write.
- R3: A data byte received after the command drives `reg_we_o` for that cycle, with `reg_waddr_o` equal to the pointer and `reg_wdata_o` equal to the byte. This holds when the pointer is a writable address: output, polarity, configuration or mask index 0 to 4, or 0x28 to 0x2A.
- R4: Data bytes aimed at the input group (0x00 to 0x04) raise no write strobe.
- R5: `reg_raddr_o` always equals the pointer. For a mapped address, `tx_data_o` equals `reg_rdata_i`.
- R6: With auto-increment set, the pointer advances once per received data byte and once per `tx_done_i` in a read.
- R7: With auto-increment set, the pointer steps from index 4 of a group back to index 0 of the same group, and from 0x2A back to 0x28.
- R8: With auto-increment clear, data bytes and completed reads leave the pointer unchanged.
- R9: A write to the mode register (0x2A) always presents bits 7:5 as zero on `reg_wdata_o`.
- R10: `stop_i` returns the block to idle while keeping the pointer. Bytes received while idle write nothing.
- R11: At reserved addresses (slot index 5 to 7 of a group, and 0x2B to 0x3F), writes raise no strobe and `tx_data_o` reads 0x00.
- R12: From any address not covered by R7, auto-increment adds one, wrapping 0x3F to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Pulse: slave address matched, transfer begins |
| rnw_i | input | 1 | Direction qualifying `sel_i`: 1 read, 0 write |
| rx_valid_i | input | 1 | Pulse: a byte was received from the master |
| rx_data_i | input | 8 | Received byte |
| tx_done_i | input | 1 | Pulse: a byte was sent to the master |
| stop_i | input | 1 | Pulse: stop condition seen |
| tx_data_o | output | 8 | Byte to send for the current pointer |
| reg_raddr_o | output | 6 | Storage read address |
| reg_rdata_i | input | 8 | Storage read data |
| reg_we_o | output | 1 | Storage write strobe |
| reg_waddr_o | output | 6 | Storage write address |
| reg_wdata_o | output | 8 | Storage write data |

## Verification
Write bursts begin inside the output group with auto-increment set and carry six bytes. This shows whether the pointer steps by one or folds back to 0x08 after index 4. Reads repeat that walk from a second group and compare `tx_data_o` against an address-tagged storage model. The same model also shows whether reserved addresses return zero. Bursts aimed at the input group, at reserved slots and at the top address are used to tell the strobe gating apart from the pointer stepping, and this includes the 0x3F to 0x00 wrap. A control-register burst checks the mode-bit masking and the 0x2A to 0x28 fold. Bytes sent without auto-increment, or while idle after a stop, show that the pointer holds still and that nothing is written.

// File: rtl/regptr_pkg.sv
package regptr_pkg;
  localparam int PTR_W     = 6;
  localparam int DATA_W    = 8;
  localparam int SLOT_BITS = 3;
  localparam int SLOT_W    = PTR_W - SLOT_BITS;

  localparam logic [SLOT_W-1:0]    INPUT_SLOT  = SLOT_W'(0);
  localparam logic [SLOT_W-1:0]    GROUP_SLOTS = SLOT_W'(5);
  localparam logic [SLOT_W-1:0]    CTRL_SLOT   = SLOT_W'(5);
  localparam logic [SLOT_BITS-1:0] GROUP_LAST  = SLOT_BITS'(4);
  localparam logic [SLOT_BITS-1:0] CTRL_LAST   = SLOT_BITS'(2);
  localparam logic [SLOT_BITS-1:0] MODE_IDX    = SLOT_BITS'(2);
  localparam logic [DATA_W-1:0]    MODE_KEEP   = DATA_W'(8'h1F);

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_WDATA, PH_RDATA} phase_e;

  typedef struct packed {
    logic mapped;
    logic writable;
    logic is_mode;
  } addr_class_t;

  function automatic addr_class_t classify(input logic [PTR_W-1:0] a);
    addr_class_t c;
    logic [SLOT_W-1:0]    slot;
    logic [SLOT_BITS-1:0] idx;
    slot = a[PTR_W-1:SLOT_BITS];
    idx  = a[SLOT_BITS-1:0];
    c.mapped   = ((slot < GROUP_SLOTS) && (idx <= GROUP_LAST)) ||
                 ((slot == CTRL_SLOT) && (idx <= CTRL_LAST));
    c.writable = c.mapped && (slot != INPUT_SLOT);
    c.is_mode  = (slot == CTRL_SLOT) && (idx == MODE_IDX);
    return c;
  endfunction

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] a);
    logic [SLOT_W-1:0]    slot;
    logic [SLOT_BITS-1:0] idx;
    slot = a[PTR_W-1:SLOT_BITS];
    idx  = a[SLOT_BITS-1:0];
    if ((slot < GROUP_SLOTS) && (idx == GROUP_LAST))
      return {slot, {SLOT_BITS{1'b0}}};
    else if ((slot == CTRL_SLOT) && (idx == CTRL_LAST))
      return {slot, {SLOT_BITS{1'b0}}};
    else
      return a + 1'b1;
  endfunction
endpackage

// File: rtl/regptr_classify.sv
module regptr_classify
  import regptr_pkg::*;
#(
  parameter int AW = PTR_W
) (
  input  logic [AW-1:0] addr_i,
  output addr_class_t   cls_o,
  output logic [AW-1:0] step_o
);
  always_comb begin
    cls_o  = classify(addr_i);
    step_o = next_ptr(addr_i);
  end
endmodule

// File: rtl/regptr_seq.sv
module regptr_seq
  import regptr_pkg::*;
#(
  parameter int AW = PTR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  logic          rnw_i,
  input  logic          rx_valid_i,
  input  logic [AW-1:0] cmd_ptr_i,
  input  logic          cmd_ai_i,
  input  logic          tx_done_i,
  input  logic          stop_i,
  input  logic [AW-1:0] step_i,
  output logic [AW-1:0] ptr_o,
  output logic          ai_o,
  output phase_e        phase_o,
  output logic          cmd_take_o,
  output logic          data_wr_o,
  output logic          rd_adv_o
);
  phase_e        phase_q;
  logic [AW-1:0] ptr_q;
  logic          ai_q;
  logic          quiet;

  assign quiet      = !stop_i && !sel_i;
  assign cmd_take_o = quiet && rx_valid_i && (phase_q == PH_CMD);
  assign data_wr_o  = quiet && rx_valid_i && (phase_q == PH_WDATA);
  assign rd_adv_o   = quiet && tx_done_i  && (phase_q == PH_RDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ptr_q   <= '0;
      ai_q    <= 1'b0;
    end else begin
      if (stop_i)
        phase_q <= PH_IDLE;
      else if (sel_i)
        phase_q <= rnw_i ? PH_RDATA : PH_CMD;
      else if (cmd_take_o)
        phase_q <= PH_WDATA;

      if (cmd_take_o) begin
        ptr_q <= cmd_ptr_i;
        ai_q  <= cmd_ai_i;
      end else if ((data_wr_o || rd_adv_o) && ai_q) begin
        ptr_q <= step_i;
      end
    end
  end

  assign ptr_o   = ptr_q;
  assign ai_o    = ai_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/regptr_top.sv
module regptr_top
  import regptr_pkg::*;
#(
  parameter int AW = PTR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  logic          rnw_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          tx_done_i,
  input  logic          stop_i,
  output logic [DW-1:0] tx_data_o,
  output logic [AW-1:0] reg_raddr_o,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          reg_we_o,
  output logic [AW-1:0] reg_waddr_o,
  output logic [DW-1:0] reg_wdata_o
);
  localparam int AI_BIT = DW - 1;

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] step;
  logic          ai_q;
  phase_e        phase_q;
  addr_class_t   cls;
  logic          cmd_take;
  logic          data_wr;
  logic          rd_adv;

  regptr_classify #(.AW(AW)) u_cls (
    .addr_i (ptr_q),
    .cls_o  (cls),
    .step_o (step)
  );

  regptr_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_i),
    .rnw_i      (rnw_i),
    .rx_valid_i (rx_valid_i),
    .cmd_ptr_i  (rx_data_i[AW-1:0]),
    .cmd_ai_i   (rx_data_i[AI_BIT]),
    .tx_done_i  (tx_done_i),
    .stop_i     (stop_i),
    .step_i     (step),
    .ptr_o      (ptr_q),
    .ai_o       (ai_q),
    .phase_o    (phase_q),
    .cmd_take_o (cmd_take),
    .data_wr_o  (data_wr),
    .rd_adv_o   (rd_adv)
  );

  assign reg_raddr_o = ptr_q;
  assign tx_data_o   = cls.mapped ? reg_rdata_i : '0;
  assign reg_we_o    = data_wr && cls.writable;
  assign reg_waddr_o = ptr_q;
  assign reg_wdata_o = cls.is_mode ? (rx_data_i & MODE_KEEP) : rx_data_i;
endmodule

// File: rtl/regptr_checker.sv
module regptr_checker
  import regptr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  ptr_q,
  input logic        ai_q,
  input phase_e      phase_q,
  input logic        cmd_take,
  input logic        data_wr,
  input logic        rd_adv,
  input logic        reg_we_o,
  input logic [5:0]  reg_waddr_o,
  input logic [7:0]  reg_wdata_o,
  input logic [7:0]  tx_data_o,
  input logic [5:0]  reg_raddr_o
);
  assert_cmd_nowrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |-> !reg_we_o);

  assert_input_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> (reg_waddr_o > 6'h04));

  assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_wr || rd_adv) && ai_q) |=> (ptr_q != $past(ptr_q)));

  assert_group_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_wr || rd_adv) && ai_q && (ptr_q[2:0] == 3'd4) && (ptr_q[5:3] < 3'd5))
      |=> ((ptr_q[2:0] == 3'd0) && (ptr_q[5:3] == $past(ptr_q[5:3]))));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_wr || rd_adv) && !ai_q) |=> (ptr_q == $past(ptr_q)));

  assert_mode_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o && (reg_waddr_o == 6'h2A)) |-> (reg_wdata_o[7:5] == 3'b000));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> !reg_we_o);

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_raddr_o > 6'h2A) |-> (tx_data_o == 8'h00));
endmodule

bind regptr_top regptr_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ptr_q       (ptr_q),
  .ai_q        (ai_q),
  .phase_q     (phase_q),
  .cmd_take    (cmd_take),
  .data_wr     (data_wr),
  .rd_adv      (rd_adv),
  .reg_we_o    (reg_we_o),
  .reg_waddr_o (reg_waddr_o),
  .reg_wdata_o (reg_wdata_o),
  .tx_data_o   (tx_data_o),
  .reg_raddr_o (reg_raddr_o)
);

// File: tb/tb_regptr_top.sv
`timescale 1ns/1ps
module tb_regptr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_i = 1'b0, rnw_i = 1'b0, rx_valid_i = 1'b0, tx_done_i = 1'b0, stop_i = 1'b0;
  logic [7:0] rx_data_i = 8'h00;
  logic [7:0] tx_data_o, reg_rdata_i, reg_wdata_o;
  logic [5:0] reg_raddr_o, reg_waddr_o;
  logic       reg_we_o;

  int checks = 0;
  int fails  = 0;
  int mptr   = 0;
  bit mai    = 0;

  always #2 clk = ~clk;
  assign reg_rdata_i = {2'b11, reg_raddr_o};

  regptr_top dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .rnw_i(rnw_i),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .tx_done_i(tx_done_i),
    .stop_i(stop_i), .tx_data_o(tx_data_o), .reg_raddr_o(reg_raddr_o),
    .reg_rdata_i(reg_rdata_i), .reg_we_o(reg_we_o), .reg_waddr_o(reg_waddr_o),
    .reg_wdata_o(reg_wdata_o)
  );

  function automatic bit m_mapped(int a);
    int g = a / 8, i = a % 8;
    return (g <= 4 && i <= 4) || (g == 5 && i <= 2);
  endfunction
  function automatic bit m_writable(int a);
    return m_mapped(a) && (a >= 8);
  endfunction
  function automatic int m_next(int a);
    int g = a / 8, i = a % 8;
    if (g <= 4 && i == 4) return g * 8;
    if (g == 5 && i == 2) return 40;
    return (a + 1) % 64;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_sel(bit rd);
    @(negedge clk); sel_i = 1'b1; rnw_i = rd;
    @(negedge clk); sel_i = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask

  // R2: command byte loads pointer and flag, writes nothing
  task automatic begin_write(logic [7:0] cmd);
    do_sel(1'b0);
    @(negedge clk); rx_valid_i = 1'b1; rx_data_i = cmd;
    #1 chk(reg_we_o == 1'b0, "R2 cmd byte strobe", reg_we_o, 0);
    @(negedge clk); rx_valid_i = 1'b0;
    mptr = cmd[5:0]; mai = cmd[7];
    #1 chk(reg_raddr_o == 6'(mptr), "R2 pointer load", reg_raddr_o, mptr);
  endtask

  task automatic wr_data(logic [7:0] d);
    int  old = mptr;
    bit  w   = m_writable(mptr);
    logic [7:0] expd = (mptr == 42) ? (d & 8'h1F) : d;
    string tag = w ? ((mptr == 42) ? "R9" : "R3") : ((mptr < 8) ? "R4" : "R11");
    @(negedge clk); rx_valid_i = 1'b1; rx_data_i = d;
    #1 chk(reg_we_o == w, {tag, " strobe"}, reg_we_o, w);
    if (w) begin
      chk(reg_waddr_o == 6'(mptr), {tag, " waddr"}, reg_waddr_o, mptr);
      chk(reg_wdata_o == expd, {tag, " wdata"}, reg_wdata_o, expd);
    end
    @(negedge clk); rx_valid_i = 1'b0;
    if (mai) mptr = m_next(mptr);
    tag = !mai ? "R8" : ((old % 8 == 4 && old < 40) || old == 42) ? "R7" : (old == 63 ? "R12" : "R6");
    #1 chk(reg_raddr_o == 6'(mptr), {tag, " pointer step"}, reg_raddr_o, mptr);
  endtask

  task automatic rd_data();
    int  old = mptr;
    logic [7:0] expd = m_mapped(mptr) ? (8'hC0 | 8'(mptr)) : 8'h00;
    string tag;
    @(negedge clk); tx_done_i = 1'b1;
    #1 chk(reg_raddr_o == 6'(mptr), "R5 raddr", reg_raddr_o, mptr);
    chk(tx_data_o == expd, m_mapped(mptr) ? "R5 tx data" : "R11 tx zero", tx_data_o, expd);
    @(negedge clk); tx_done_i = 1'b0;
    if (mai) mptr = m_next(mptr);
    tag = !mai ? "R8" : ((old % 8 == 4 && old < 40) || old == 42) ? "R7" : "R6";
    #1 chk(reg_raddr_o == 6'(mptr), {tag, " read step"}, reg_raddr_o, mptr);
  endtask

  task automatic t_reset();
    chk(reg_raddr_o == 6'h00, "R1 pointer", reg_raddr_o, 0);
    chk(reg_we_o == 1'b0, "R1 strobe", reg_we_o, 0);
    chk(tx_data_o == 8'hC0, "R1 tx", tx_data_o, 8'hC0);
    @(negedge clk); rx_valid_i = 1'b1; rx_data_i = 8'h55;
    #1 chk(reg_we_o == 1'b0, "R1 idle byte", reg_we_o, 0);
    @(negedge clk); rx_valid_i = 1'b0;
    #1 chk(reg_raddr_o == 6'h00, "R1 idle pointer", reg_raddr_o, 0);
  endtask

  task automatic t_output_burst();
    begin_write(8'h88);
    for (int k = 0; k < 6; k++) wr_data(8'h11 + 8'(k));
    do_stop();
  endtask

  task automatic t_read_burst();
    begin_write(8'h9B);
    do_sel(1'b1);
    for (int k = 0; k < 7; k++) rd_data();
    do_stop();
  endtask

  task automatic t_no_increment();
    begin_write(8'h12);
    for (int k = 0; k < 3; k++) wr_data(8'hA0 + 8'(k));
    do_sel(1'b1);
    rd_data(); rd_data();
    do_stop();
  endtask

  task automatic t_input_group();
    begin_write(8'h82);
    for (int k = 0; k < 4; k++) wr_data(8'h3C);
    do_stop();
  endtask

  task automatic t_reserved();
    begin_write(8'h85);
    wr_data(8'h77); wr_data(8'h78);
    do_sel(1'b1); rd_data();
    do_stop();
    begin_write(8'hAB);
    wr_data(8'h99);
    do_stop();
    begin_write(8'hBF);
    wr_data(8'h42);
    do_stop();
  endtask

  task automatic t_control();
    begin_write(8'hA8);
    wr_data(8'hFF); wr_data(8'hFF); wr_data(8'hFF); wr_data(8'hEE);
    do_sel(1'b1);
    for (int k = 0; k < 4; k++) rd_data();
    do_stop();
  endtask

  task automatic t_idle_after_stop();
    begin_write(8'h9A);
    do_stop();
    @(negedge clk); rx_valid_i = 1'b1; rx_data_i = 8'hC3;
    #1 chk(reg_we_o == 1'b0, "R10 idle write", reg_we_o, 0);
    @(negedge clk); rx_valid_i = 1'b0;
    #1 chk(reg_raddr_o == 6'h1A, "R10 pointer kept", reg_raddr_o, 8'h1A);
    do_sel(1'b1); rd_data();
    do_stop();
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 t_reset();
    t_output_burst();
    t_read_burst();
    t_no_increment();
    t_input_group();
    t_reserved();
    t_control();
    t_idle_after_stop();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule